// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-facing register file of a multi-channel DMA controller. A simple single-cycle bus (write enable, read enable, a word address and 32-bit data) reaches three groups of storage: a 16-byte window per channel with four parameter words, a table of per-channel line strides, and a set of shared registers. The shared registers hold the pending-completion flags, the interrupt mask, the loop (cyclic) control and the channel abort command. The per-channel address engines sit outside the block. They receive each channel's parameters, a start strobe and an abort strobe, and they report completions back on `done_i`. The block merges the unmasked pending flags into one interrupt line.

Software can change shared state in two ways: by writing a whole register (read-modify-write), or through dedicated clear aliases that drop only the bits written as one, so no read is needed. The pending flags clear when a one is written to them. A completion that lands in the same cycle as such a clear keeps its flag set.

Reads pass through a two-state access sequencer, `S_IDLE` and `S_RESP`. A read request sampled at a clock edge moves the sequencer from `S_IDLE` (or from `S_RESP`, for back-to-back reads) to `S_RESP`. In `S_RESP` the sequencer presents the captured word with `rd_valid_o` high. It returns to `S_IDLE` on the next edge that carries no read request. Writes are taken directly at the clock edge and do not involve the sequencer.

Top module: `dma_ctl_regbank`

## Requirements
- R1: After reset, every parameter, stride, flag, mask and loop bit is zero, `irq_o`, `rd_valid_o` and all strobes are low, and reads of every register return zero.
- R2: Channel n's window starts at n*0x10. It holds the buffer address at +0x0, line length at +0x4, line count at +0x8 and control at +0xC. Each word reads back what was last written and appears on the matching `ch_*_o` slice [32n+31:32n].
- R3: The stride word of channel n sits at 0x100 + 4n, reads back as written and drives `ch_stride_o` slice n.
- R4: In the control word, bits [3:0] hold the channel number and are stored as written. Bit 4 drives `ch_burst_o[n]` and bit 5 drives `ch_dir_o[n]`.
- R5: A write to channel n's address word (+0x0) raises `start_o[n]` for exactly the one cycle after the write edge. Writes to the other three words of the window raise no start strobe.
- R6: Writing to 0x140 raises `abort_o[n]` for one cycle for every bit n written as one. The register reads as zero.
- R7: The pending register at 0x144 sets bit n at the edge where `done_i[n]` is high. Writing a one to bit n clears it, and a zero leaves it unchanged. If a clear and a completion hit the same bit at the same edge, the bit stays set.
- R8: The mask at 0x148 takes the whole written word. Writing ones to 0x14C clears only those mask bits. 0x14C reads as zero.
- R9: The loop register at 0x150 stores bit n and bit n+16 for channel n. `loop_en_o[n]` is high only when both are set. Writing ones to 0x15C clears those bits, and 0x15C reads as zero.
- R10: `irq_o` is high exactly when some channel has both its pending flag and its mask bit set. It follows the registered state with no further delay.
- R11: Reads of unmapped or non-word-aligned addresses return zero with `rd_valid_o`. Writes to them change no register and raise no strobe.
- R12: Every read request sampled at an edge produces `rd_valid_o` and its data in the following cycle only, and reads on consecutive cycles are each answered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write request for this cycle |
| rd_en_i | input | 1 | Read request for this cycle |
| addr_i | input | ADDR_W | Byte address of the accessed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read response strobe |
| done_i | input | NUM_CH | Per-channel completion events |
| ch_addr_o | output | NUM_CH*32 | Buffer address per channel |
| ch_xlen_o | output | NUM_CH*32 | Line length per channel |
| ch_ylen_o | output | NUM_CH*32 | Line count per channel |
| ch_ctrl_o | output | NUM_CH*32 | Control word per channel |
| ch_stride_o | output | NUM_CH*32 | Line stride per channel |
| ch_burst_o | output | NUM_CH | Burst-mode flag per channel |
| ch_dir_o | output | NUM_CH | Direction flag per channel |
| start_o | output | NUM_CH | One-cycle start strobe per channel |
| abort_o | output | NUM_CH | One-cycle abort strobe per channel |
| loop_en_o | output | NUM_CH | Loop mode active per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
A write sampled at a clock edge is visible in the next cycle: the stored words, the decoded flags and the one-cycle start and abort strobes all appear there. A completion sampled at an edge sets its flag and, when the channel is unmasked, raises `irq_o` in that same following cycle. Read data arrives one cycle after the request together with `rd_valid_o`. The bench drives every input at the falling edge and samples one falling edge later. Expected read data is queued when the request is issued and matched in order as each response appears, so a response that is late, early or missing shows up as a mismatch or as queued items left over.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    localparam int DW        = 32;
    localparam int CH_IDX_W  = 4;
    localparam int WIN_BYTES = 16;
    localparam int LOOP_HI   = 16;

    localparam logic [11:0] OFF_STRIDE  = 12'h100;
    localparam logic [11:0] OFF_ABORT   = 12'h140;
    localparam logic [11:0] OFF_PEND    = 12'h144;
    localparam logic [11:0] OFF_MASK    = 12'h148;
    localparam logic [11:0] OFF_MASKCLR = 12'h14C;
    localparam logic [11:0] OFF_LOOP    = 12'h150;
    localparam logic [11:0] OFF_LOOPCLR = 12'h15C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CHAN,
        RG_STRIDE,
        RG_ABORT,
        RG_PEND,
        RG_MASK,
        RG_MASKCLR,
        RG_LOOP,
        RG_LOOPCLR
    } region_e;

    typedef enum logic [1:0] {
        CF_BUF   = 2'd0,
        CF_LLEN  = 2'd1,
        CF_LCNT  = 2'd2,
        CF_CTRL  = 2'd3
    } chfield_e;

    typedef struct packed {
        region_e               region;
        chfield_e              field;
        logic [CH_IDX_W-1:0]   ch;
    } dec_t;

    typedef enum logic {
        S_IDLE,
        S_RESP
    } acc_state_e;

endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] CHAN_END   = ADDR_W'(NUM_CH * WIN_BYTES);
    localparam logic [ADDR_W-1:0] STRIDE_LO  = ADDR_W'(OFF_STRIDE);
    localparam logic [ADDR_W-1:0] STRIDE_END = ADDR_W'(int'(OFF_STRIDE) + NUM_CH * 4);

    always_comb begin
        dec.region = RG_NONE;
        dec.field  = CF_BUF;
        dec.ch     = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr < CHAN_END) begin
                dec.region = RG_CHAN;
                dec.field  = chfield_e'(addr[3:2]);
                dec.ch     = addr[7:4];
            end else if (addr >= STRIDE_LO && addr < STRIDE_END) begin
                dec.region = RG_STRIDE;
                dec.ch     = addr[5:2];
            end else begin
                case (addr)
                    ADDR_W'(OFF_ABORT):   dec.region = RG_ABORT;
                    ADDR_W'(OFF_PEND):    dec.region = RG_PEND;
                    ADDR_W'(OFF_MASK):    dec.region = RG_MASK;
                    ADDR_W'(OFF_MASKCLR): dec.region = RG_MASKCLR;
                    ADDR_W'(OFF_LOOP):    dec.region = RG_LOOP;
                    ADDR_W'(OFF_LOOPCLR): dec.region = RG_LOOPCLR;
                    default:              dec.region = RG_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmarb_chan_regs.sv
module dmarb_chan_regs
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  dec_t                 dec,
    input  logic [DW-1:0]        wdata,
    output logic [NUM_CH*DW-1:0] buf_o,
    output logic [NUM_CH*DW-1:0] llen_o,
    output logic [NUM_CH*DW-1:0] lcnt_o,
    output logic [NUM_CH*DW-1:0] ctrl_o,
    output logic [NUM_CH*DW-1:0] stride_o,
    output logic [NUM_CH-1:0]    burst_o,
    output logic [NUM_CH-1:0]    dir_o,
    output logic [NUM_CH-1:0]    start_o,
    output logic [DW-1:0]        rd_data
);

    localparam int BURST_BIT = 4;
    localparam int DIR_BIT   = 5;

    logic [DW-1:0] buf_q    [NUM_CH];
    logic [DW-1:0] llen_q   [NUM_CH];
    logic [DW-1:0] lcnt_q   [NUM_CH];
    logic [DW-1:0] ctrl_q   [NUM_CH];
    logic [DW-1:0] stride_q [NUM_CH];
    logic          start_q  [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic win_hit;
        logic str_hit;

        assign win_hit = wr_en && (dec.region == RG_CHAN)   && (dec.ch == CH_IDX_W'(g));
        assign str_hit = wr_en && (dec.region == RG_STRIDE) && (dec.ch == CH_IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_q[g]    <= '0;
                llen_q[g]   <= '0;
                lcnt_q[g]   <= '0;
                ctrl_q[g]   <= '0;
                stride_q[g] <= '0;
                start_q[g]  <= 1'b0;
            end else begin
                start_q[g] <= win_hit && (dec.field == CF_BUF);
                if (win_hit) begin
                    unique case (dec.field)
                        CF_BUF:  buf_q[g]  <= wdata;
                        CF_LLEN: llen_q[g] <= wdata;
                        CF_LCNT: lcnt_q[g] <= wdata;
                        CF_CTRL: ctrl_q[g] <= wdata;
                    endcase
                end
                if (str_hit) begin
                    stride_q[g] <= wdata;
                end
            end
        end

        assign buf_o[g*DW +: DW]    = buf_q[g];
        assign llen_o[g*DW +: DW]   = llen_q[g];
        assign lcnt_o[g*DW +: DW]   = lcnt_q[g];
        assign ctrl_o[g*DW +: DW]   = ctrl_q[g];
        assign stride_o[g*DW +: DW] = stride_q[g];
        assign burst_o[g]           = ctrl_q[g][BURST_BIT];
        assign dir_o[g]             = ctrl_q[g][DIR_BIT];
        assign start_o[g]           = start_q[g];

        AST_NO_START_ON_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
            (win_hit && dec.field != CF_BUF) |=> !start_q[g]); // R5
    end

    always_comb begin
        rd_data = '0;
        if (dec.region == RG_CHAN) begin
            unique case (dec.field)
                CF_BUF:  rd_data = buf_q[dec.ch];
                CF_LLEN: rd_data = llen_q[dec.ch];
                CF_LCNT: rd_data = lcnt_q[dec.ch];
                CF_CTRL: rd_data = ctrl_q[dec.ch];
            endcase
        end else if (dec.region == RG_STRIDE) begin
            rd_data = stride_q[dec.ch];
        end
    end

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o)); // R5

endmodule

// File: rtl/dmarb_glob_regs.sv
module dmarb_glob_regs
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  region_e           region,
    input  logic [DW-1:0]     wdata,
    input  logic [NUM_CH-1:0] done_i,
    output logic [NUM_CH-1:0] abort_o,
    output logic [NUM_CH-1:0] loop_en_o,
    output logic              irq_o,
    output logic [DW-1:0]     rd_data
);

    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] loop_lo_q;
    logic [NUM_CH-1:0] loop_hi_q;
    logic [NUM_CH-1:0] abort_q;

    logic [NUM_CH-1:0] wlo;
    logic [NUM_CH-1:0] whi;
    logic [NUM_CH-1:0] pend_clr;

    assign wlo      = wdata[NUM_CH-1:0];
    assign whi      = wdata[LOOP_HI +: NUM_CH];
    assign pend_clr = (wr_en && region == RG_PEND) ? wlo : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            mask_q    <= '0;
            loop_lo_q <= '0;
            loop_hi_q <= '0;
            abort_q   <= '0;
        end else begin
            pend_q  <= (pend_q & ~pend_clr) | done_i;
            abort_q <= (wr_en && region == RG_ABORT) ? wlo : '0;
            if (wr_en) begin
                case (region)
                    RG_MASK:    mask_q <= wlo;
                    RG_MASKCLR: mask_q <= mask_q & ~wlo;
                    RG_LOOP: begin
                        loop_lo_q <= wlo;
                        loop_hi_q <= whi;
                    end
                    RG_LOOPCLR: begin
                        loop_lo_q <= loop_lo_q & ~wlo;
                        loop_hi_q <= loop_hi_q & ~whi;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign abort_o   = abort_q;
    assign loop_en_o = loop_lo_q & loop_hi_q;
    assign irq_o     = |(pend_q & mask_q);

    always_comb begin
        rd_data = '0;
        case (region)
            RG_PEND: rd_data[NUM_CH-1:0] = pend_q;
            RG_MASK: rd_data[NUM_CH-1:0] = mask_q;
            RG_LOOP: begin
                rd_data[NUM_CH-1:0]        = loop_lo_q;
                rd_data[LOOP_HI +: NUM_CH] = loop_hi_q;
            end
            default: rd_data = '0;
        endcase
    end

    AST_EVENT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((pend_q & $past(done_i)) == $past(done_i))); // R7

    AST_MASKCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_MASKCLR) |=> ((mask_q & $past(wlo)) == '0)); // R8

    AST_LOOPCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_LOOPCLR) |=> ((loop_en_o & $past(wlo | whi)) == '0)); // R9

    AST_ABORT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && region == RG_ABORT) |=> (abort_o == '0)); // R6

    AST_IRQ_OFF_AFTER_FULL_MASKCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_MASKCLR && (&wlo)) |=> !irq_o); // R10

endmodule

// File: rtl/dma_ctl_regbank.sv
module dma_ctl_regbank
    import dmarb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output logic                 rd_valid_o,
    input  logic [NUM_CH-1:0]    done_i,
    output logic [NUM_CH*32-1:0] ch_addr_o,
    output logic [NUM_CH*32-1:0] ch_xlen_o,
    output logic [NUM_CH*32-1:0] ch_ylen_o,
    output logic [NUM_CH*32-1:0] ch_ctrl_o,
    output logic [NUM_CH*32-1:0] ch_stride_o,
    output logic [NUM_CH-1:0]    ch_burst_o,
    output logic [NUM_CH-1:0]    ch_dir_o,
    output logic [NUM_CH-1:0]    start_o,
    output logic [NUM_CH-1:0]    abort_o,
    output logic [NUM_CH-1:0]    loop_en_o,
    output logic                 irq_o
);

    dec_t          dec;
    logic [DW-1:0] chan_rd;
    logic [DW-1:0] glob_rd;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    acc_state_e    state_q;
    acc_state_e    state_d;

    dmarb_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (addr_i),
        .dec  (dec)
    );

    dmarb_chan_regs #(
        .NUM_CH (NUM_CH)
    ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .dec      (dec),
        .wdata    (wdata_i),
        .buf_o    (ch_addr_o),
        .llen_o   (ch_xlen_o),
        .lcnt_o   (ch_ylen_o),
        .ctrl_o   (ch_ctrl_o),
        .stride_o (ch_stride_o),
        .burst_o  (ch_burst_o),
        .dir_o    (ch_dir_o),
        .start_o  (start_o),
        .rd_data  (chan_rd)
    );

    dmarb_glob_regs #(
        .NUM_CH (NUM_CH)
    ) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .region    (dec.region),
        .wdata     (wdata_i),
        .done_i    (done_i),
        .abort_o   (abort_o),
        .loop_en_o (loop_en_o),
        .irq_o     (irq_o),
        .rd_data   (glob_rd)
    );

    assign rd_mux = chan_rd | glob_rd;

    // State register: access sequencer and captured read word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en_i) begin
                rdata_q <= rd_mux;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        state_d    = rd_en_i ? S_RESP : S_IDLE;
        rd_valid_o = 1'b0;
        rdata_o    = '0;
        unique case (state_q)
            S_IDLE: begin
                rd_valid_o = 1'b0;
                rdata_o    = '0;
            end
            S_RESP: begin
                rd_valid_o = 1'b1;
                rdata_o    = rdata_q;
            end
        endcase
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R12

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o); // R12

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && dec.region == RG_NONE) |=> (rdata_o == '0)); // R11

    AST_UNMAPPED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && dec.region == RG_NONE) |=> (start_o == '0 && abort_o == '0)); // R11

endmodule

// File: tb/dma_ctl_regbank_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_regbank_tb_top;

    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en_i = 1'b0;
    logic                 rd_en_i = 1'b0;
    logic [ADDR_W-1:0]    addr_i = '0;
    logic [31:0]          wdata_i = '0;
    logic [31:0]          rdata_o;
    logic                 rd_valid_o;
    logic [NUM_CH-1:0]    done_i = '0;
    logic [NUM_CH*32-1:0] ch_addr_o, ch_xlen_o, ch_ylen_o, ch_ctrl_o, ch_stride_o;
    logic [NUM_CH-1:0]    ch_burst_o, ch_dir_o, start_o, abort_o, loop_en_o;
    logic                 irq_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];

    always #2.5 clk = ~clk;

    dma_ctl_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rd_valid_o(rd_valid_o),
        .done_i(done_i), .ch_addr_o(ch_addr_o), .ch_xlen_o(ch_xlen_o),
        .ch_ylen_o(ch_ylen_o), .ch_ctrl_o(ch_ctrl_o), .ch_stride_o(ch_stride_o),
        .ch_burst_o(ch_burst_o), .ch_dir_o(ch_dir_o), .start_o(start_o),
        .abort_o(abort_o), .loop_en_o(loop_en_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wr_evt(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [NUM_CH-1:0] ev);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d; done_i = ev;
        @(negedge clk);
        wr_en_i = 1'b0; done_i = '0;
    endtask

    task automatic evt(input logic [NUM_CH-1:0] ev);
        @(negedge clk);
        done_i = ev;
        @(negedge clk);
        done_i = '0;
    endtask

    // Driver: queue the expected word, then issue the request
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        @(negedge clk);
        exp_q.push_back(it);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic rd2(input logic [ADDR_W-1:0] a0, input logic [31:0] e0,
                       input logic [ADDR_W-1:0] a1, input logic [31:0] e1, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = e0; it.tag = tag; exp_q.push_back(it);
        rd_en_i = 1'b1; addr_i = a0;
        @(negedge clk);
        it.exp = e1; it.tag = tag; exp_q.push_back(it);
        addr_i = a1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    // Monitor: pop and compare each response as it appears
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", rdata_o, 32'h0);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(rdata_o === it.exp, it.tag, rdata_o, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq_o == 1'b0 && rd_valid_o == 1'b0, "R1 irq/valid after reset", {30'b0, irq_o, rd_valid_o}, 32'h0);
        check(start_o == '0 && abort_o == '0 && loop_en_o == '0, "R1 strobes after reset",
              {start_o, abort_o}, 32'h0);
        rd(12'h050, 32'h0, "R1 buffer word reset");
        rd(12'h144, 32'h0, "R1 pending reset");
        rd(12'h150, 32'h0, "R1 loop reset");

        // R2 / R5 channel window
        wr(12'h050, 32'hA5A5_0000);
        check(start_o == 16'h0020, "R5 start pulse ch5", {16'h0, start_o}, 32'h0020);
        @(negedge clk);
        check(start_o == 16'h0000, "R5 start lasts one cycle", {16'h0, start_o}, 32'h0);
        wr(12'h054, 32'h0000_0020);
        check(start_o == 16'h0000, "R5 no start on line length", {16'h0, start_o}, 32'h0);
        wr(12'h058, 32'h0000_0007);
        wr(12'h0F0, 32'h1234_5678);
        check(ch_addr_o[5*32 +: 32] == 32'hA5A5_0000, "R2 ch5 buffer port", ch_addr_o[5*32 +: 32], 32'hA5A5_0000);
        check(ch_ylen_o[5*32 +: 32] == 32'h7, "R2 ch5 line count port", ch_ylen_o[5*32 +: 32], 32'h7);
        rd(12'h050, 32'hA5A5_0000, "R2 ch5 buffer read");
        rd(12'h054, 32'h0000_0020, "R2 ch5 line length read");
        rd(12'h0F0, 32'h1234_5678, "R2 ch15 buffer read");

        // R4 control flags
        wr(12'h03C, 32'h0000_0033);
        check(ch_burst_o[3] && ch_dir_o[3], "R4 burst and dir set", {30'b0, ch_burst_o[3], ch_dir_o[3]}, 32'h3);
        wr(12'h03C, 32'h0000_0023);
        check(!ch_burst_o[3] && ch_dir_o[3], "R4 dir only", {30'b0, ch_burst_o[3], ch_dir_o[3]}, 32'h1);
        check(ch_ctrl_o[3*32 +: 4] == 4'h3, "R4 channel number field", {28'b0, ch_ctrl_o[3*32 +: 4]}, 32'h3);
        rd(12'h03C, 32'h0000_0023, "R4 control read");

        // R3 strides
        wr(12'h11C, 32'h0000_0040);
        wr(12'h13C, 32'h0000_0099);
        check(ch_stride_o[7*32 +: 32] == 32'h40, "R3 ch7 stride port", ch_stride_o[7*32 +: 32], 32'h40);
        rd(12'h11C, 32'h0000_0040, "R3 ch7 stride read");
        rd(12'h13C, 32'h0000_0099, "R3 ch15 stride read");

        // R6 abort
        wr(12'h140, 32'h0000_8001);
        check(abort_o == 16'h8001, "R6 abort pulse", {16'h0, abort_o}, 32'h8001);
        @(negedge clk);
        check(abort_o == 16'h0, "R6 abort one cycle", {16'h0, abort_o}, 32'h0);
        rd(12'h140, 32'h0, "R6 abort reads zero");

        // R7 / R10 pending and interrupt
        wr(12'h148, 32'h0000_0003);
        evt(16'h0006);
        check(irq_o == 1'b1, "R10 irq on unmasked pending", {31'b0, irq_o}, 32'h1);
        rd(12'h144, 32'h0000_0006, "R7 pending set by events");
        wr(12'h144, 32'h0000_0002);
        check(irq_o == 1'b0, "R10 irq drops when only masked pending", {31'b0, irq_o}, 32'h0);
        wr(12'h144, 32'h0000_0000);
        rd(12'h144, 32'h0000_0004, "R7 zero write no effect");
        wr_evt(12'h144, 32'h0000_0004, 16'h0004);
        rd(12'h144, 32'h0000_0004, "R7 event wins over clear");

        // R8 mask and mask clear
        wr(12'h148, 32'h0000_FFFF);
        check(irq_o == 1'b1, "R10 irq after unmask ch2", {31'b0, irq_o}, 32'h1);
        wr(12'h14C, 32'h0000_00F0);
        rd(12'h148, 32'h0000_FF0F, "R8 mask clear is selective");
        rd(12'h14C, 32'h0, "R8 mask clear reads zero");
        wr(12'h14C, 32'h0000_FFFF);
        check(irq_o == 1'b0, "R10 irq off with all masked", {31'b0, irq_o}, 32'h0);

        // R9 loop control
        wr(12'h150, 32'h0001_0003);
        check(loop_en_o == 16'h0001, "R9 loop needs both bits", {16'h0, loop_en_o}, 32'h1);
        rd(12'h150, 32'h0001_0003, "R9 loop read");
        wr(12'h15C, 32'h0001_0000);
        check(loop_en_o == 16'h0000, "R9 loop clear upper bit", {16'h0, loop_en_o}, 32'h0);
        rd(12'h150, 32'h0000_0003, "R9 loop after clear");
        rd(12'h15C, 32'h0, "R9 loop clear reads zero");

        // R11 unmapped and unaligned
        wr(12'h154, 32'hFFFF_FFFF);
        rd(12'h154, 32'h0, "R11 unmapped reads zero");
        rd(12'h150, 32'h0000_0003, "R11 unmapped write ignored");
        wr(12'h051, 32'h0000_DEAD);
        check(start_o == 16'h0, "R11 unaligned write no start", {16'h0, start_o}, 32'h0);
        rd(12'h050, 32'hA5A5_0000, "R11 unaligned write ignored");
        rd(12'h200, 32'h0, "R11 high unmapped reads zero");

        // R12 back-to-back reads
        rd2(12'h11C, 32'h0000_0040, 12'h054, 32'h0000_0020, "R12 back-to-back reads");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule